// File: doc/BRIEF.md
# Burst Packet Address Compressor

This block formats outgoing burst packets into a byte stream and shortens the address field where it can. A packet is a write burst, a read request or a read response. It has a 32-bit address, a length of 1 to 16 words and an optional per-word byte-enable mask. The block keeps the address of the last packet that carried one. It sends only the address bytes that differ from that stored address, and a mask byte tells the far end which bytes follow. Read responses have no address field at all. One control input turns compression off so that every address byte is sent.

The packet header comes in on a valid/ready handshake that is open only while the block is idle. Data words are pulled one at a time on a second handshake. The byte stream leaves on a valid/ready handshake, and the last byte of each packet is flagged. A matching unpacker inside the block watches the accepted output bytes, rebuilds the full address from its own stored copy, and reports it on a pulse output. This gives a loopback check of the compression.

Top module: `pkt_addr_compressor`

## Requirements
- R1: After reset, outValid is low and inReady is high.
- R2: The first byte of each packet is the command byte: bits 7:6 hold the kind (0 write burst, 1 read request, 2 read response), bit 5 is 1 when byte enables are sent, bit 4 is 0, and bits 3:0 hold the word count minus one. The command byte is offered in the cycle after the header is accepted.
- R3: For write bursts and read requests, a mask byte follows the command byte. Mask bit i (bits 3:0) set to 1 means address byte i (address bits 8i+7:8i) follows. Bits 7:4 are 0. The address bytes that are present follow in ascending index order.
- R4: The first address-carrying packet after reset has mask 0xF.
- R5: Every later address-carrying packet sets a mask bit only for the bytes that differ from the stored address. If all four bytes match, the mask is 0 and no address byte is sent.
- R6: While optDisable is 1, the mask is 0xF whatever the stored address holds.
- R7: A read response sends neither mask nor address, and it leaves the stored address unchanged.
- R8: Write bursts and read responses send count words, each as four bytes with the least significant first. Read requests send no data bytes.
- R9: When byte enables are on, one byte whose bits 3:0 hold that word's enables comes just before each data word.
- R10: Every packet ends with the byte 0xFD. outLast is high with that byte and with no other byte.
- R11: inReady is low from the acceptance of a header until the handshake of its end byte.
- R12: While outValid is high and outReady is low, outValid and outData hold their values into the next cycle.
- R13: In the cycle after the handshake of the last address byte (or of the mask byte when the mask is 0), rxAddrValid is high for one cycle and rxAddr holds the full address of that packet.
- R14: A 16-word burst is carried in full, with count field 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| optDisable | input | 1 | 1 forces all address bytes to be sent |
| inValid | input | 1 | Header offered |
| inReady | output | 1 | Header accepted when high with inValid |
| inKind | input | 2 | Packet kind: 0 write, 1 read request, 2 read response |
| inAddr | input | 32 | Packet address |
| inBeOn | input | 1 | Send a byte-enable byte before each word |
| inLenM1 | input | 4 | Word count minus one |
| wordValid | input | 1 | Data word offered |
| wordReady | output | 1 | Data word taken when high with wordValid |
| wordData | input | 32 | Data word |
| wordBe | input | 4 | Byte enables of the data word |
| outValid | output | 1 | Stream byte valid |
| outReady | input | 1 | Stream sink ready |
| outData | output | 8 | Stream byte |
| outLast | output | 1 | Marks the end byte |
| rxAddrValid | output | 1 | One-cycle pulse: rebuilt address ready |
| rxAddr | output | 32 | Address rebuilt by the loopback unpacker |

## Verification
The command byte is due one cycle after the header handshake. Each later byte appears one cycle after the handshake of the byte before it, except that fetching each data word costs one idle cycle. The rebuilt address pulse comes one cycle after its last address byte is accepted. Because every result trails its cause by a handshake, the bench does not count fixed cycles. It records each accepted byte and each address pulse at the falling edge, then compares the whole packet with a reference stream built from the requirements once the end byte has passed. Input and backpressure changes happen away from the sampling edge, and the hold and busy rules are checked at every falling edge while a packet is running.

// File: rtl/pkt_cmp_pkg.sv
package pkt_cmp_pkg;

  localparam logic [7:0] END_CODE = 8'hFD;

  typedef enum logic [1:0] {
    KIND_WRITE = 2'd0,
    KIND_RDREQ = 2'd1,
    KIND_RDRSP = 2'd2
  } pktKind_e;

  typedef enum logic [2:0] {
    SEL_CMD,
    SEL_MASK,
    SEL_ADDR,
    SEL_BE,
    SEL_DATA,
    SEL_END
  } outSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    loadHdr;
    logic    loadWord;
    logic    nextAddr;
    logic    nextByte;
    outSel_e sel;
  } dpCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic hasAddr;
    logic hasData;
    logic beOn;
    logic addrNone;
    logic addrOnLast;
    logic byteLast;
    logic wordLast;
  } dpStat_t;

endpackage

// File: rtl/pkt_cmp_datapath.sv
module pkt_cmp_datapath
  import pkt_cmp_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int DATA_BYTES = 4,
  parameter int MAX_WORDS  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtl_t                  ctl,
  input  logic                    optDisable,
  input  logic [1:0]              inKind,
  input  logic [8*ADDR_BYTES-1:0] inAddr,
  input  logic                    inBeOn,
  input  logic [$clog2(MAX_WORDS)-1:0] inLenM1,
  input  logic [8*DATA_BYTES-1:0] wordData,
  input  logic [DATA_BYTES-1:0]   wordBe,
  output dpStat_t                 stat,
  output logic [7:0]              outData
);
  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int DATA_W = 8 * DATA_BYTES;
  localparam int LEN_W  = $clog2(MAX_WORDS);
  localparam int IDX_W  = $clog2(ADDR_BYTES);
  localparam int BIDX_W = $clog2(DATA_BYTES);

  pktKind_e               hdrKind;
  logic [ADDR_W-1:0]      hdrAddr;
  logic                   hdrBe;
  logic [LEN_W-1:0]       hdrLen;
  logic [ADDR_BYTES-1:0]  pendMask;
  logic [ADDR_W-1:0]      lastAddr;
  logic                   lastValid;
  logic [DATA_W-1:0]      curWord;
  logic [DATA_BYTES-1:0]  curBe;
  logic [BIDX_W-1:0]      byteIdx;
  logic [LEN_W:0]         wordsLoaded;

  logic [ADDR_BYTES-1:0]  newMask;
  logic [IDX_W-1:0]       lowIdx;
  pktKind_e               inKindE;

  assign inKindE = pktKind_e'(inKind);

  // per-byte change detection against the stored address
  generate
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : gDiff
      always_comb begin
        if (inKindE == KIND_RDRSP)
          newMask[g] = 1'b0;
        else if (!lastValid || optDisable)
          newMask[g] = 1'b1;
        else
          newMask[g] = (inAddr[8*g +: 8] != lastAddr[8*g +: 8]);
      end
    end
  endgenerate

  always_comb begin
    lowIdx = '0;
    for (int i = ADDR_BYTES - 1; i >= 0; i--)
      if (pendMask[i]) lowIdx = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrKind     <= KIND_WRITE;
      hdrAddr     <= '0;
      hdrBe       <= 1'b0;
      hdrLen      <= '0;
      pendMask    <= '0;
      lastAddr    <= '0;
      lastValid   <= 1'b0;
      curWord     <= '0;
      curBe       <= '0;
      byteIdx     <= '0;
      wordsLoaded <= '0;
    end else begin
      if (ctl.loadHdr) begin
        hdrKind     <= inKindE;
        hdrAddr     <= inAddr;
        hdrBe       <= inBeOn;
        hdrLen      <= inLenM1;
        pendMask    <= newMask;
        wordsLoaded <= '0;
        if (inKindE != KIND_RDRSP) begin
          lastAddr  <= inAddr;
          lastValid <= 1'b1;
        end
      end
      if (ctl.nextAddr)
        pendMask <= pendMask & (pendMask - 1'b1);
      if (ctl.loadWord) begin
        curWord     <= wordData;
        curBe       <= wordBe;
        byteIdx     <= '0;
        wordsLoaded <= wordsLoaded + 1'b1;
      end
      if (ctl.nextByte)
        byteIdx <= byteIdx + 1'b1;
    end
  end

  always_comb begin
    stat.hasAddr    = (hdrKind != KIND_RDRSP);
    stat.hasData    = (hdrKind != KIND_RDREQ);
    stat.beOn       = hdrBe;
    stat.addrNone   = (pendMask == '0);
    stat.addrOnLast = ((pendMask & (pendMask - 1'b1)) == '0);
    stat.byteLast   = (byteIdx == BIDX_W'(DATA_BYTES - 1));
    stat.wordLast   = (wordsLoaded == ({1'b0, hdrLen} + 1'b1));
  end

  always_comb begin
    case (ctl.sel)
      SEL_CMD:  outData = {hdrKind, hdrBe, 1'b0, 4'(hdrLen)};
      SEL_MASK: outData = 8'(pendMask);
      SEL_ADDR: outData = hdrAddr[{lowIdx, 3'b000} +: 8];
      SEL_BE:   outData = 8'(curBe);
      SEL_DATA: outData = curWord[{byteIdx, 3'b000} +: 8];
      default:  outData = END_CODE;
    endcase
  end

endmodule

// File: rtl/pkt_cmp_control.sv
module pkt_cmp_control
  import pkt_cmp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    wordValid,
  input  logic    outReady,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    inReady,
  output logic    wordReady,
  output logic    outValid,
  output logic    outLast
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_MASK, ST_ADDR, ST_LOADW, ST_BE, ST_DATA, ST_END
  } state_e;

  state_e state, stateNext, afterAddr;
  logic   fire;

  assign fire      = outValid && outReady;
  assign afterAddr = stat.hasData ? ST_LOADW : ST_END;

  always_comb begin
    stateNext    = state;
    ctl          = '0;
    ctl.sel      = SEL_END;
    inReady      = 1'b0;
    wordReady    = 1'b0;
    outValid     = 1'b0;
    outLast      = 1'b0;
    case (state)
      ST_IDLE: begin
        inReady = 1'b1;
        if (inValid) begin
          ctl.loadHdr = 1'b1;
          stateNext   = ST_CMD;
        end
      end
      ST_CMD: begin
        outValid = 1'b1;
        ctl.sel  = SEL_CMD;
        if (fire) stateNext = stat.hasAddr ? ST_MASK : ST_LOADW;
      end
      ST_MASK: begin
        outValid = 1'b1;
        ctl.sel  = SEL_MASK;
        if (fire) stateNext = stat.addrNone ? afterAddr : ST_ADDR;
      end
      ST_ADDR: begin
        outValid = 1'b1;
        ctl.sel  = SEL_ADDR;
        if (fire) begin
          ctl.nextAddr = 1'b1;
          if (stat.addrOnLast) stateNext = afterAddr;
        end
      end
      ST_LOADW: begin
        wordReady = 1'b1;
        if (wordValid) begin
          ctl.loadWord = 1'b1;
          stateNext    = stat.beOn ? ST_BE : ST_DATA;
        end
      end
      ST_BE: begin
        outValid = 1'b1;
        ctl.sel  = SEL_BE;
        if (fire) stateNext = ST_DATA;
      end
      ST_DATA: begin
        outValid = 1'b1;
        ctl.sel  = SEL_DATA;
        if (fire) begin
          ctl.nextByte = 1'b1;
          if (stat.byteLast) stateNext = stat.wordLast ? ST_END : ST_LOADW;
        end
      end
      default: begin
        outValid = 1'b1;
        outLast  = 1'b1;
        ctl.sel  = SEL_END;
        if (fire) stateNext = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/pkt_cmp_unpack.sv
module pkt_cmp_unpack
  import pkt_cmp_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int DATA_BYTES = 4,
  parameter int MAX_WORDS  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    byteValid,
  input  logic [7:0]              byteData,
  output logic                    rxAddrValid,
  output logic [8*ADDR_BYTES-1:0] rxAddr
);
  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int LEN_W  = $clog2(MAX_WORDS);
  localparam int IDX_W  = $clog2(ADDR_BYTES);
  localparam int BIDX_W = $clog2(DATA_BYTES);

  typedef enum logic [2:0] {U_CMD, U_MASK, U_ADDR, U_BE, U_DATA, U_END} uState_e;

  uState_e               state;
  pktKind_e              kind;
  logic                  beOn;
  logic [LEN_W-1:0]      lenM1;
  logic [LEN_W-1:0]      wordCnt;
  logic [BIDX_W-1:0]     byteCnt;
  logic [ADDR_BYTES-1:0] pend;
  logic [ADDR_W-1:0]     work;
  logic [ADDR_W-1:0]     lastAddr;
  logic [ADDR_W-1:0]     merged;
  logic [IDX_W-1:0]      lowIdx;
  uState_e               afterAddr;

  always_comb begin
    lowIdx = '0;
    for (int i = ADDR_BYTES - 1; i >= 0; i--)
      if (pend[i]) lowIdx = IDX_W'(i);
    merged = work;
    merged[{lowIdx, 3'b000} +: 8] = byteData;
    afterAddr = (kind == KIND_RDREQ) ? U_END : (beOn ? U_BE : U_DATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= U_CMD;
      kind        <= KIND_WRITE;
      beOn        <= 1'b0;
      lenM1       <= '0;
      wordCnt     <= '0;
      byteCnt     <= '0;
      pend        <= '0;
      work        <= '0;
      lastAddr    <= '0;
      rxAddr      <= '0;
      rxAddrValid <= 1'b0;
    end else begin
      rxAddrValid <= 1'b0;
      if (byteValid) begin
        case (state)
          U_CMD: begin
            kind    <= pktKind_e'(byteData[7:6]);
            beOn    <= byteData[5];
            lenM1   <= byteData[LEN_W-1:0];
            wordCnt <= '0;
            byteCnt <= '0;
            if (pktKind_e'(byteData[7:6]) == KIND_RDRSP)
              state <= byteData[5] ? U_BE : U_DATA;
            else
              state <= U_MASK;
          end
          U_MASK: begin
            pend <= byteData[ADDR_BYTES-1:0];
            work <= lastAddr;
            if (byteData[ADDR_BYTES-1:0] == '0) begin
              rxAddr      <= lastAddr;
              rxAddrValid <= 1'b1;
              state       <= afterAddr;
            end else begin
              state <= U_ADDR;
            end
          end
          U_ADDR: begin
            pend <= pend & (pend - 1'b1);
            work <= merged;
            if ((pend & (pend - 1'b1)) == '0) begin
              rxAddr      <= merged;
              lastAddr    <= merged;
              rxAddrValid <= 1'b1;
              state       <= afterAddr;
            end
          end
          U_BE: state <= U_DATA;
          U_DATA: begin
            byteCnt <= byteCnt + 1'b1;
            if (byteCnt == BIDX_W'(DATA_BYTES - 1)) begin
              byteCnt <= '0;
              wordCnt <= wordCnt + 1'b1;
              if (wordCnt == lenM1) state <= U_END;
              else                  state <= beOn ? U_BE : U_DATA;
            end
          end
          default: state <= U_CMD;
        endcase
      end
    end
  end

endmodule

// File: rtl/pkt_addr_compressor.sv
module pkt_addr_compressor
  import pkt_cmp_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int DATA_BYTES = 4,
  parameter int MAX_WORDS  = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          optDisable,
  input  logic                          inValid,
  output logic                          inReady,
  input  logic [1:0]                    inKind,
  input  logic [8*ADDR_BYTES-1:0]       inAddr,
  input  logic                          inBeOn,
  input  logic [$clog2(MAX_WORDS)-1:0]  inLenM1,
  input  logic                          wordValid,
  output logic                          wordReady,
  input  logic [8*DATA_BYTES-1:0]       wordData,
  input  logic [DATA_BYTES-1:0]         wordBe,
  output logic                          outValid,
  input  logic                          outReady,
  output logic [7:0]                    outData,
  output logic                          outLast,
  output logic                          rxAddrValid,
  output logic [8*ADDR_BYTES-1:0]       rxAddr
);
  dpCtl_t  ctl;
  dpStat_t stat;

  pkt_cmp_control uCtl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .wordValid(wordValid),
    .outReady(outReady), .stat(stat), .ctl(ctl), .inReady(inReady),
    .wordReady(wordReady), .outValid(outValid), .outLast(outLast)
  );

  pkt_cmp_datapath #(
    .ADDR_BYTES(ADDR_BYTES), .DATA_BYTES(DATA_BYTES), .MAX_WORDS(MAX_WORDS)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .optDisable(optDisable),
    .inKind(inKind), .inAddr(inAddr), .inBeOn(inBeOn), .inLenM1(inLenM1),
    .wordData(wordData), .wordBe(wordBe), .stat(stat), .outData(outData)
  );

  pkt_cmp_unpack #(
    .ADDR_BYTES(ADDR_BYTES), .DATA_BYTES(DATA_BYTES), .MAX_WORDS(MAX_WORDS)
  ) uUnpack (
    .clk(clk), .rstN(rstN), .byteValid(outValid && outReady),
    .byteData(outData), .rxAddrValid(rxAddrValid), .rxAddr(rxAddr)
  );

endmodule

// File: rtl/pkt_cmp_checker.sv
module pkt_cmp_checker
  import pkt_cmp_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       inReady,
  input logic       outValid,
  input logic       outReady,
  input logic [7:0] outData,
  input logic       outLast,
  input logic       rxAddrValid
);
  // R12: a stalled byte stays put
  a_r12_hold: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData));

  // R10: the flagged byte is the end code
  a_r10_end_code: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outLast |-> outData == END_CODE);

  // R11: no header is taken while a packet is on the stream
  a_r11_busy: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  // R2: command byte follows an accepted header, bit 4 clear
  a_r2_cmd_next: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> outValid && !outData[4] && !outLast);

  // R13: rebuilt address is a single-cycle pulse
  a_r13_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxAddrValid |=> !rxAddrValid);
endmodule

bind pkt_addr_compressor pkt_cmp_checker uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outData(outData),
  .outLast(outLast), .rxAddrValid(rxAddrValid)
);

// File: tb/sim_pkt_addr_compressor.sv
`timescale 1ns/1ps
module sim_pkt_addr_compressor;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        optDisable = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [1:0]  inKind = 2'd0;
  logic [31:0] inAddr = '0;
  logic        inBeOn = 1'b0;
  logic [3:0]  inLenM1 = '0;
  logic        wordValid = 1'b0;
  logic        wordReady;
  logic [31:0] wordData = '0;
  logic [3:0]  wordBe = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [7:0]  outData;
  logic        outLast;
  logic        rxAddrValid;
  logic [31:0] rxAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pkt_addr_compressor u0 (
    .clk(clk), .rstN(rstN), .optDisable(optDisable), .inValid(inValid),
    .inReady(inReady), .inKind(inKind), .inAddr(inAddr), .inBeOn(inBeOn),
    .inLenM1(inLenM1), .wordValid(wordValid), .wordReady(wordReady),
    .wordData(wordData), .wordBe(wordBe), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outLast(outLast),
    .rxAddrValid(rxAddrValid), .rxAddr(rxAddr)
  );

  // stream monitor
  logic [7:0]  got[$];
  logic        gotLast[$];
  int          pktsDone = 0;
  int          rxCnt = 0;
  logic [31:0] rxLast = '0;
  int          busyViol = 0;
  int          holdViol = 0;
  bit          prevStall = 1'b0;
  logic [7:0]  prevData = '0;
  bit          bpMode = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall && (!outValid || outData !== prevData)) holdViol++;
      prevStall = outValid && !outReady;
      prevData  = outData;
      if (outValid && inReady) busyViol++;
      if (rxAddrValid) begin
        rxCnt++;
        rxLast = rxAddr;
      end
      if (outValid && outReady) begin
        got.push_back(outData);
        gotLast.push_back(outLast);
        if (outLast) pktsDone++;
      end
    end else begin
      prevStall = 1'b0;
    end
  end

  always @(posedge clk) begin
    #2;
    if (bpMode) outReady = ~outReady;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // reference model state
  logic [31:0] mLast = '0;
  bit          mLastValid = 1'b0;
  logic [31:0] wordsBuf[16];
  logic [3:0]  beBuf[16];

  task automatic doReset();
    rstN = 1'b0;
    mLastValid = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic sendPkt(input logic [1:0] kind, input logic [31:0] addr,
                         input bit be, input int len, input string tag,
                         input logic [3:0] expMask);
    logic [7:0] exp[$];
    logic [3:0] mask;
    int nWords;
    int startPk;
    int startRx;
    // build the reference stream
    exp.push_back({kind, be, 1'b0, 4'(len - 1)});
    if (kind != 2'd2) begin
      for (int i = 0; i < 4; i++)
        mask[i] = (!mLastValid || optDisable) ? 1'b1 : (addr[8*i +: 8] != mLast[8*i +: 8]);
      chk(mask == expMask, tag, "model mask", 64'(mask), 64'(expMask));
      exp.push_back({4'h0, mask});
      for (int i = 0; i < 4; i++)
        if (mask[i]) exp.push_back(addr[8*i +: 8]);
      mLast = addr;
      mLastValid = 1'b1;
    end
    nWords = (kind != 2'd1) ? len : 0;
    for (int w = 0; w < nWords; w++) begin
      if (be) exp.push_back({4'h0, beBuf[w]});
      for (int b = 0; b < 4; b++) exp.push_back(wordsBuf[w][8*b +: 8]);
    end
    exp.push_back(8'hFD);

    got.delete();
    gotLast.delete();
    startPk = pktsDone;
    startRx = rxCnt;
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid = 1'b1; inKind = kind; inAddr = addr; inBeOn = be; inLenM1 = 4'(len - 1);
    @(posedge clk);
    #1 inValid = 1'b0;
    for (int w = 0; w < nWords; w++) begin
      @(negedge clk);
      while (!wordReady) @(negedge clk);
      wordValid = 1'b1; wordData = wordsBuf[w]; wordBe = beBuf[w];
      @(posedge clk);
      #1 wordValid = 1'b0;
    end
    while (pktsDone == startPk) @(negedge clk);

    chk(got.size() == exp.size(), tag, "packet length", 64'(got.size()), 64'(exp.size()));
    for (int i = 0; i < exp.size() && i < got.size(); i++) begin
      chk(got[i] == exp[i], tag, $sformatf("byte %0d", i), 64'(got[i]), 64'(exp[i]));
      chk(gotLast[i] == (i == exp.size() - 1), "R10", $sformatf("last flag byte %0d", i),
          64'(gotLast[i]), 64'(i == exp.size() - 1));
    end
    if (kind != 2'd2) begin
      chk(rxCnt == startRx + 1, "R13", "address pulses", 64'(rxCnt - startRx), 64'd1);
      chk(rxLast == addr, "R13", "rebuilt address", 64'(rxLast), 64'(addr));
    end else begin
      chk(rxCnt == startRx, "R7", "no address pulse on response", 64'(rxCnt - startRx), 64'd0);
    end
    chk(busyViol == 0, "R11", "inReady during packet", 64'(busyViol), 64'd0);
  endtask

  task automatic fillWords(input int n, input logic [31:0] seed);
    for (int w = 0; w < n; w++) begin
      wordsBuf[w] = seed ^ (32'h01010101 * 32'(w + 1));
      beBuf[w]    = 4'(w + 3);
    end
  endtask

  task automatic tReset();
    doReset();
    @(negedge clk);
    chk(outValid == 1'b0, "R1", "outValid after reset", 64'(outValid), 64'd0);
    chk(inReady == 1'b1, "R1", "inReady after reset", 64'(inReady), 64'd1);
  endtask

  task automatic tFirstWrite();
    fillWords(2, 32'hA5A50000);
    sendPkt(2'd0, 32'h12345678, 1'b0, 2, "R4 R2 R3 R8", 4'hF);
  endtask

  task automatic tSameAddr();
    sendPkt(2'd1, 32'h12345678, 1'b0, 4, "R5 R8 read request", 4'h0);
  endtask

  task automatic tPartialBe();
    fillWords(3, 32'h0BADF00D);
    sendPkt(2'd0, 32'h12AB5678, 1'b1, 3, "R5 R9", 4'h4);
  endtask

  task automatic tResponse();
    fillWords(2, 32'hCAFE0000);
    sendPkt(2'd2, 32'hFFFFFFFF, 1'b1, 2, "R7 R8 response", 4'h0);
    fillWords(1, 32'h11112222);
    sendPkt(2'd0, 32'h12AB5678, 1'b0, 1, "R7 store kept", 4'h0);
  endtask

  task automatic tDisable();
    optDisable = 1'b1;
    sendPkt(2'd1, 32'h12AB5678, 1'b0, 1, "R6", 4'hF);
    optDisable = 1'b0;
  endtask

  task automatic tLongBackpressure();
    fillWords(16, 32'h76543210);
    bpMode = 1'b1;
    sendPkt(2'd0, 32'h12AB0000, 1'b1, 16, "R14 R12", 4'h3);
    bpMode = 1'b0;
    @(posedge clk);
    #2 outReady = 1'b1;
    chk(holdViol == 0, "R12", "stalled byte changed", 64'(holdViol), 64'd0);
  endtask

  task automatic tReReset();
    tReset();
    fillWords(1, 32'h5555AAAA);
    sendPkt(2'd0, 32'h12AB0000, 1'b0, 1, "R4 after second reset", 4'hF);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    tReset();
    tFirstWrite();
    tSameAddr();
    tPartialBe();
    tResponse();
    tDisable();
    tLongBackpressure();
    tReReset();
    repeat (4) @(posedge clk);
    finish();
  end

endmodule